// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of an interval timer. It runs in the system clock domain and samples a slower count clock. It acts on each falling edge of that count clock. A host-side register block hands it two things: a mode code with a one-cycle "mode written" strobe, and a reload value with its own one-cycle strobe. The channel shows its live count and drives one output pin.

Six waveform behaviours are available: an output that rises at terminal count, a gate-triggered one-shot, a periodic rate pulse, a square wave, a software-started strobe and a gate-triggered strobe. The gate input has a different meaning in each group. In the software-started modes, gate low pauses counting. In the periodic modes, gate low pauses counting and also forces the output high. In the gate-triggered modes, only a rising gate edge matters, and it starts or restarts the count. An initial load and a gate restart both take place at the next falling count-clock edge. In the periodic modes, a value rewritten while the channel is running waits for the next terminal count.

Top module: `pitChannel`

## Requirements
- R1: After reset, outPin is high, count is 0, and no counting happens until a mode and then a reload value have been written.
- R2: Mode codes are 0 (terminal-count flag), 1 (gate one-shot), 2 (rate pulse), 3 (square wave), 4 (software strobe) and 5 (gate strobe); codes 6 and 7 act as 2 and 3. An accepted reload value reaches count on the next falling count-clock edge after the write. Each later falling edge that counts lowers count by one, except in mode 3.
- R3: Writing mode 0 drives outPin low on the next system clock. It stays low until count steps from 1 to 0, and it then goes high. A reload write in mode 0 drives outPin low again and restarts the load.
- R4: In modes 0 and 4, gate low freezes count at its present value and leaves outPin unchanged. Counting resumes from that value once gate is high again.
- R5: In modes 1 and 5, only a gate rising edge that comes after a reload write starts the count, at the next falling edge. A later rising edge reloads the count again. Gate level does not pause the countdown. In mode 1, outPin is low from the load until count steps from 1 to 0.
- R6: In mode 2 with reload N, outPin goes low on the falling edge that takes count from 2 to 1. On the next falling edge count reloads to N and outPin goes high, so the period is N edges.
- R7: In mode 3, an even reload N toggles outPin every N/2 falling edges, with count stepping down by 2. An odd N gives (N+1)/2 edges high and (N-1)/2 edges low.
- R8: In modes 2 and 3, gate low forces outPin high on the next system clock and freezes count. A gate rising edge makes count reload at the next falling edge.
- R9: In modes 2 and 3, a reload value written while the channel is running first takes effect at the next terminal-count reload.
- R10: In modes 2 and 3, a reload write of value 1 is ignored, and the previous reload value stays in use.
- R11: A reload value of 0 counts as 65536: count loads 0, and the next counting edge takes it to 65535.
- R12: In modes 4 and 5, outPin goes low on the falling edge where count reaches 0. It returns high on the next falling edge. It pulses only once per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntClk | input | 1 | Slow count clock, sampled by clk; acts on its falling edge |
| gate | input | 1 | Gate input, with a meaning that depends on the mode |
| modeWr | input | 1 | One-cycle strobe: modeIn is a new mode |
| modeIn | input | 3 | Mode code (see R2) |
| reloadWr | input | 1 | One-cycle strobe: reloadIn is a new reload value |
| reloadIn | input | 16 | Reload value (0 means 65536) |
| count | output | 16 | Live current count |
| outPin | output | 1 | Channel output |

## Verification
The assertions assume that cntClk changes far more slowly than clk. They assume each falling edge is held for at least one clk cycle, and that modeWr and reloadWr are single-cycle pulses that never coincide with a sampled falling edge. The checker follows the mode from the modeWr and modeIn ports alone, so it also assumes that every mode change arrives through that strobe. The bench drives every input on the falling system clock edge. It makes each count-clock edge last several cycles, and it issues register writes only between count edges. This keeps the stimulus within those assumptions and makes the expected count and output a simple function of how many edges have been applied.

// File: rtl/pitPkg.sv
package pitPkg;

  typedef enum logic [2:0] {
    MODE_TC       = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } pitMode_e;

  // Strobes from control to datapath for one system clock
  typedef struct packed {
    logic       loadCount;   // copy reload register into count
    logic       decEn;       // lower count by decSel
    logic [1:0] decSel;      // step size 1, 2 or 3
    logic       takeReload;  // capture reloadIn
  } pitStrobe_t;

  // Codes 6 and 7 fold onto the two periodic modes
  function automatic pitMode_e normMode(input logic [2:0] m);
    if (m[2] && m[1]) return pitMode_e'({1'b0, m[1:0]});
    return pitMode_e'(m);
  endfunction

endpackage

// File: rtl/pitDatapath.sv
module pitDatapath
  import pitPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadIn,
  output logic [CNT_W-1:0] count,
  output logic             cntOdd,
  output logic             eqTwo,
  output logic             wouldTerm
);

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] decAmt;

  assign decAmt = {{(CNT_W-2){1'b0}}, strobe.decSel};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
      countReg  <= '0;
    end else begin
      if (strobe.takeReload) reloadReg <= reloadIn;
      if (strobe.loadCount)  countReg  <= reloadReg;
      else if (strobe.decEn) countReg  <= countReg - decAmt;
    end
  end

  // Zero stands for the full range, so it never terminates on one step
  assign wouldTerm = (countReg != '0) && (countReg <= decAmt);
  assign eqTwo     = (countReg == CNT_W'(2));
  assign cntOdd    = countReg[0];
  assign count     = countReg;

endmodule

// File: rtl/pitControl.sv
module pitControl
  import pitPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntClk,
  input  logic             gate,
  input  logic             modeWr,
  input  logic [2:0]       modeIn,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadIn,
  input  logic             cntOdd,
  input  logic             eqTwo,
  input  logic             wouldTerm,
  output pitStrobe_t       strobe,
  output logic             outPin
);

  logic     cntQ, gateQ;
  pitMode_e modeReg;
  logic     outReg, loadPend, trigPend, armed, running;

  logic tick, gateRise;
  logic isHw, isPer, isSw;
  logic accept, doLoad, cntStep, periodicTerm;
  logic [1:0] decSel;

  assign tick     = cntQ & ~cntClk;
  assign gateRise = gate & ~gateQ;

  assign isHw  = (modeReg == MODE_ONESHOT) || (modeReg == MODE_HWSTROBE);
  assign isPer = (modeReg == MODE_RATE)    || (modeReg == MODE_SQUARE);
  assign isSw  = (modeReg == MODE_TC)      || (modeReg == MODE_SWSTROBE);

  assign accept  = reloadWr && !modeWr && !(isPer && (reloadIn == CNT_W'(1)));
  assign doLoad  = tick && !modeWr &&
                   (isHw ? trigPend : (loadPend && (!isPer || gate)));
  assign cntStep = tick && !modeWr && !doLoad && running && (isHw || gate);

  always_comb begin
    decSel = 2'd1;
    if (modeReg == MODE_SQUARE) begin
      if (!cntOdd)     decSel = 2'd2;
      else if (outReg) decSel = 2'd1;
      else             decSel = 2'd3;
    end
  end

  assign periodicTerm = cntStep && isPer && wouldTerm;

  always_comb begin
    strobe.loadCount  = doLoad || periodicTerm;
    strobe.decEn      = cntStep && !periodicTerm;
    strobe.decSel     = decSel;
    strobe.takeReload = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= 1'b0;
      gateQ    <= 1'b0;
      modeReg  <= MODE_TC;
      outReg   <= 1'b1;
      loadPend <= 1'b0;
      trigPend <= 1'b0;
      armed    <= 1'b0;
      running  <= 1'b0;
    end else begin
      cntQ  <= cntClk;
      gateQ <= gate;
      if (modeWr) begin
        modeReg  <= normMode(modeIn);
        outReg   <= (normMode(modeIn) != MODE_TC);
        loadPend <= 1'b0;
        trigPend <= 1'b0;
        armed    <= 1'b0;
        running  <= 1'b0;
      end else begin
        if (tick) begin
          // strobe pulse ends one count period after it began
          if (!isSw && !isHw) begin
          end else if ((modeReg == MODE_SWSTROBE || modeReg == MODE_HWSTROBE) && !outReg)
            outReg <= 1'b1;
          if (doLoad) begin
            running  <= 1'b1;
            loadPend <= 1'b0;
            trigPend <= 1'b0;
            if (modeReg == MODE_ONESHOT) outReg <= 1'b0;
            if (isPer)                   outReg <= 1'b1;
          end else if (cntStep) begin
            unique case (modeReg)
              MODE_TC, MODE_ONESHOT: if (wouldTerm) begin
                outReg  <= 1'b1;
                running <= 1'b0;
              end
              MODE_SWSTROBE, MODE_HWSTROBE: if (wouldTerm) begin
                outReg  <= 1'b0;
                running <= 1'b0;
              end
              MODE_RATE: begin
                if (eqTwo)     outReg <= 1'b0;
                if (wouldTerm) outReg <= 1'b1;
              end
              MODE_SQUARE: if (wouldTerm) outReg <= ~outReg;
              default: ;
            endcase
          end
        end
        if (accept) begin
          if (isHw) armed <= 1'b1;
          if (isSw) begin
            loadPend <= 1'b1;
            running  <= 1'b0;
            if (modeReg == MODE_TC) outReg <= 1'b0;
          end
          if (isPer && !running) loadPend <= 1'b1;
        end
        if (gateRise) begin
          if (isHw && armed)   trigPend <= 1'b1;
          if (isPer && running) loadPend <= 1'b1;
        end
        if (isPer && !gate) outReg <= 1'b1;
      end
    end
  end

  assign outPin = outReg;

endmodule

// File: rtl/pitChannel.sv
module pitChannel
  import pitPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntClk,
  input  logic             gate,
  input  logic             modeWr,
  input  logic [2:0]       modeIn,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadIn,
  output logic [CNT_W-1:0] count,
  output logic             outPin
);

  pitStrobe_t strobe;
  logic       cntOdd, eqTwo, wouldTerm;

  pitControl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cntClk    (cntClk),
    .gate      (gate),
    .modeWr    (modeWr),
    .modeIn    (modeIn),
    .reloadWr  (reloadWr),
    .reloadIn  (reloadIn),
    .cntOdd    (cntOdd),
    .eqTwo     (eqTwo),
    .wouldTerm (wouldTerm),
    .strobe    (strobe),
    .outPin    (outPin)
  );

  pitDatapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reloadIn  (reloadIn),
    .count     (count),
    .cntOdd    (cntOdd),
    .eqTwo     (eqTwo),
    .wouldTerm (wouldTerm)
  );

endmodule

// File: rtl/pitChannelChk.sv
module pitChannelChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntClk,
  input logic             gate,
  input logic             modeWr,
  input logic [2:0]       modeIn,
  input logic             reloadWr,
  input logic [CNT_W-1:0] count,
  input logic             outPin
);

  logic       cntSeen;
  logic [2:0] modeSeen;
  logic       edgeNow, perMode, strobeMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntSeen  <= 1'b0;
      modeSeen <= 3'd0;
    end else begin
      cntSeen <= cntClk;
      if (modeWr) modeSeen <= modeIn;
    end
  end

  assign edgeNow    = cntSeen && !cntClk;
  assign perMode    = (modeSeen[1:0] == 2'd2 || modeSeen[1:0] == 2'd3) && (modeSeen != 3'd4) && (modeSeen != 3'd5);
  assign strobeMode = (modeSeen == 3'd4) || (modeSeen == 3'd5);

  // R2: count moves only on a sampled falling count-clock edge
  a_r2_count_only_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !edgeNow |=> $stable(count));

  // R3: writing mode 0 drives the output low
  a_r3_mode0_write_low: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && modeIn == 3'd0) |=> !outPin);

  // R3: in mode 0 the output falls only through a write
  a_r3_mode0_no_fall: assert property (@(posedge clk) disable iff (!rstN)
    (modeSeen == 3'd0 && !modeWr && !reloadWr) |=> !$fell(outPin));

  // R8: gate low in the periodic modes forces the output high
  a_r8_gate_forces_high: assert property (@(posedge clk) disable iff (!rstN)
    (perMode && !gate && !modeWr) |=> outPin);

  // R12: a strobe lasts exactly one count period
  a_r12_strobe_one_period: assert property (@(posedge clk) disable iff (!rstN)
    (strobeMode && !outPin && edgeNow && !modeWr) |=> outPin);

endmodule

bind pitChannel pitChannelChk #(.CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cntClk   (cntClk),
  .gate     (gate),
  .modeWr   (modeWr),
  .modeIn   (modeIn),
  .reloadWr (reloadWr),
  .count    (count),
  .outPin   (outPin)
);

// File: tb/sim_pitChannel.sv
`timescale 1ns/1ps
module sim_pitChannel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntClk = 1'b0;
  logic        gate = 1'b0;
  logic        modeWr = 1'b0;
  logic [2:0]  modeIn = 3'd0;
  logic        reloadWr = 1'b0;
  logic [15:0] reloadIn = 16'd0;
  logic [15:0] count;
  logic        outPin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pitChannel u0 (
    .clk(clk), .rstN(rstN), .cntClk(cntClk), .gate(gate),
    .modeWr(modeWr), .modeIn(modeIn), .reloadWr(reloadWr), .reloadIn(reloadIn),
    .count(count), .outPin(outPin)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fall();
    @(negedge clk) cntClk = 1'b1;
    @(negedge clk);
    @(negedge clk) cntClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrMode(input logic [2:0] m);
    @(negedge clk) begin modeWr = 1'b1; modeIn = m; end
    @(negedge clk) modeWr = 1'b0;
  endtask

  task automatic wrReload(input logic [15:0] v);
    @(negedge clk) begin reloadWr = 1'b1; reloadIn = v; end
    @(negedge clk) reloadWr = 1'b0;
  endtask

  task automatic setGate(input logic g);
    @(negedge clk) gate = g;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 out after reset", outPin, 1);
    chk("R1 count after reset", count, 0);
    fall();
    chk("R1 idle count", count, 0);
  endtask

  task automatic testMode0();
    setGate(1'b1);
    wrMode(3'd0);
    chk("R3 out low after mode write", outPin, 0);
    fall();
    chk("R3 no count before reload", count, 0);
    wrReload(16'd3);
    chk("R2 no load before edge", count, 0);
    fall();
    chk("R2 loaded on edge", count, 3);
    fall(); fall();
    chk("R2 decrement", count, 1);
    chk("R3 out still low", outPin, 0);
    fall();
    chk("R3 terminal count", count, 0);
    chk("R3 out high at terminal", outPin, 1);
  endtask

  task automatic testGateFreeze();
    wrMode(3'd0);
    wrReload(16'd5);
    fall(); fall();
    chk("R4 counting", count, 4);
    setGate(1'b0);
    fall(); fall();
    chk("R4 frozen count", count, 4);
    chk("R4 out unchanged", outPin, 0);
    setGate(1'b1);
    fall();
    chk("R4 resumes", count, 3);
  endtask

  task automatic testOneShot();
    setGate(1'b0);
    wrMode(3'd1);
    wrReload(16'd2);
    fall();
    chk("R5 no start without gate edge", count, 3);
    chk("R5 out high idle", outPin, 1);
    setGate(1'b1);
    fall();
    chk("R5 triggered load", count, 2);
    chk("R5 out low running", outPin, 0);
    fall(); fall();
    chk("R5 terminal", count, 0);
    chk("R5 out high at terminal", outPin, 1);
    setGate(1'b0);
    setGate(1'b1);
    fall();
    chk("R5 retrigger load", count, 2);
    chk("R5 retrigger out low", outPin, 0);
    setGate(1'b0);
    fall();
    chk("R5 gate level ignored", count, 1);
    fall();
    chk("R5 second terminal out", outPin, 1);
  endtask

  task automatic testRate();
    setGate(1'b1);
    wrMode(3'd2);
    wrReload(16'd4);
    fall();
    chk("R6 load", count, 4);
    fall(); fall();
    chk("R6 count two", count, 2);
    chk("R6 out high", outPin, 1);
    fall();
    chk("R6 pulse low at one", outPin, 0);
    @(negedge clk) gate = 1'b0;
    @(negedge clk);
    chk("R8 gate low forces high", outPin, 1);
    fall();
    chk("R8 count frozen", count, 1);
    setGate(1'b1);
    fall();
    chk("R8 gate edge reloads", count, 4);
    wrReload(16'd3);
    fall(); fall(); fall();
    chk("R6 pulse again", outPin, 0);
    chk("R9 old value still counting", count, 1);
    fall();
    chk("R9 new value at terminal", count, 3);
    chk("R6 out high after reload", outPin, 1);
    wrReload(16'd1);
    fall(); fall(); fall();
    chk("R10 value one ignored", count, 3);
    wrReload(16'd0);
    fall(); fall(); fall();
    chk("R11 zero loads", count, 0);
    fall();
    chk("R11 zero is full range", count, 65535);
  endtask

  task automatic testSquare();
    wrMode(3'd3);
    wrReload(16'd4);
    fall();
    chk("R7 even load", count, 4);
    fall();
    chk("R7 step two", count, 2);
    chk("R7 high half", outPin, 1);
    fall();
    chk("R7 toggle low", outPin, 0);
    fall(); fall();
    chk("R7 toggle high", outPin, 1);
    wrReload(16'd5);
    fall();
    chk("R9 square keeps old value", count, 2);
    fall();
    chk("R7 low phase odd load", count, 5);
    chk("R7 out low", outPin, 0);
    fall();
    chk("R7 odd low step three", count, 2);
    fall();
    chk("R7 odd low lasts two", outPin, 1);
    fall(); fall();
    chk("R7 odd high still high", outPin, 1);
    fall();
    chk("R7 odd high lasts three", outPin, 0);
    @(negedge clk) gate = 1'b0;
    @(negedge clk);
    chk("R8 square gate forces high", outPin, 1);
    setGate(1'b1);
  endtask

  task automatic testStrobes();
    wrMode(3'd4);
    wrReload(16'd2);
    fall();
    chk("R12 sw load", count, 2);
    fall(); fall();
    chk("R12 sw strobe low", outPin, 0);
    fall();
    chk("R12 sw strobe ends", outPin, 1);
    fall();
    chk("R12 sw strobe once", outPin, 1);
    chk("R12 sw count held", count, 0);
    setGate(1'b0);
    wrMode(3'd5);
    wrReload(16'd2);
    fall();
    chk("R5 hw strobe waits", count, 0);
    setGate(1'b1);
    fall();
    chk("R5 hw strobe load", count, 2);
    chk("R12 hw out high while counting", outPin, 1);
    fall(); fall();
    chk("R12 hw strobe low", outPin, 0);
    fall();
    chk("R12 hw strobe ends", outPin, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMode0();
    testGateFreeze();
    testOneShot();
    testRate();
    testSquare();
    testStrobes();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule